// File: doc/BRIEF.md
# UART Hardware Flow Control Unit

This block sits next to a UART transmitter and receiver that share a 64-entry receive FIFO. It stops the transmitter when the far end raises CTS, and only at a character boundary. It drives RTS from the receive FIFO fill level using two separate thresholds, so the pin has hysteresis. It also watches each received byte for one programmed special character and raises a sticky interrupt flag when that byte arrives. The byte is still passed on to the FIFO. A small write port holds the enable bits, the trigger levels, the special character and the 16-bit baud divisor, and it applies write gating to the extended fields and to the divisor.

The transmit side is controlled by a state machine with the states TX_RUN, TX_DRAIN and TX_HOLD. Its transitions are:
- TX_RUN to TX_HOLD when CTS is high while the transmitter is idle.
- TX_RUN to TX_DRAIN when CTS is high in the middle of a character.
- TX_DRAIN to TX_HOLD when the character ends.
- TX_DRAIN to TX_RUN when CTS goes low again.
- TX_HOLD to TX_RUN when CTS goes low or CTS control is disabled.

The RTS side is controlled by a state machine with the states RTS_OPEN and RTS_HALT. Its transitions are:
- RTS_OPEN to RTS_HALT when the level is at or above the halt threshold.
- RTS_HALT to RTS_OPEN when the level is at or below the resume threshold and below the halt threshold.

The special-character side is controlled by a state machine with the states SC_CLEAR and SC_SEEN. It moves from SC_CLEAR to SC_SEEN on a match. It returns to SC_CLEAR on the rising edge of the status read, unless a match arrives in that same cycle.

Top module: `uart_flow_ctrl`

## Requirements
- R1: After reset, all registers are zero, so the baud divisor is 0x0000. After reset, rts_pin is low, tx_permit is high and sc_irq is low.
- R2: CTS pausing is enabled by control bit 7 (address 0). While it is enabled and the transmitter is idle, tx_permit is still high 2 cycles after cts_pin rises and is low 3 cycles after it rises. tx_permit is high again 3 cycles after cts_pin falls.
- R3: When CTS rises while tx_idle is low (mid-character), tx_permit stays high. It drops 1 cycle after tx_idle rises.
- R4: When control bit 7 is 0, tx_permit stays high whatever the value of cts_pin.
- R5: RTS control is enabled by control bit 6. While it is enabled, rts_pin goes high 1 cycle after the FIFO count reaches 4 times the trigger register's bits [3:0] (the halt level). The trigger register is at address 2.
- R6: While RTS control is enabled and rts_pin is high, rts_pin goes low 1 cycle after the count drops to 4 times trigger bits [7:4] (the resume level) and is below the halt level. Between the two levels, rts_pin keeps its state.
- R7: When control bit 6 is 0, rts_pin equals bit 0 of the mode register (address 1).
- R8: Special-character detection is enabled by control bit 5. While it is enabled, a received byte equal to the special-character register (address 3) sets sc_irq on the next cycle. A byte that does not match leaves sc_irq unchanged. When detection is disabled, no byte sets sc_irq.
- R9: rx_fifo_wr follows rx_valid in the same cycle for every received byte, including a matching byte.
- R10: sc_irq stays set until a rising edge of isr_rd, which clears it once. Keeping isr_rd high does not clear it again. A match in the same cycle as the clear edge leaves sc_irq set.
- R11: Control bit 4 enables the extended fields. While it is 0, writes to the trigger register and to mode bit 1 (sleep) are ignored.
- R12: Address 4 writes divisor bits [7:0] and address 5 writes bits [15:8]. Both writes are ignored while mode bit 1 (sleep) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cts_pin | input | 1 | Clear-to-send from the far end; high means pause |
| tx_idle | input | 1 | High when the transmitter is between characters |
| tx_permit | output | 1 | Transmitter may start or continue sending |
| rx_fifo_cnt | input | 7 | Receive FIFO fill level, 0 to 64 |
| rts_pin | output | 1 | Request-to-send; high asks the far end to stop |
| rx_valid | input | 1 | Received-byte strobe |
| rx_data | input | 8 | Received byte |
| rx_fifo_wr | output | 1 | Write strobe to the receive FIFO |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| isr_rd | input | 1 | Interrupt status read; its rising edge clears sc_irq |
| sc_irq | output | 1 | Sticky special-character detected flag |
| baud_div | output | 16 | Baud divisor |

## Verification
On every cycle, the assertions check the following properties:
- tx_permit only falls while the transmitter is idle.
- rts_pin only rises at or above the halt level, and only falls at or below the resume level.
- sc_irq only rises after a matching byte, and a clear edge without a match drops it.
- Trigger and divisor writes are held off while their gate is closed.

Only the directed scenarios can show the following:
- The exact three-cycle CTS latency through the synchronizer.
- The hold band between the two RTS thresholds.
- The software-driven RTS value.
- The precedence of a set over a clear in the same cycle.
- The byte-wise assembly of the divisor.

// File: rtl/flow_pkg.sv
package flow_pkg;
    typedef enum logic [1:0] {TX_RUN, TX_DRAIN, TX_HOLD} tx_state_e;
    typedef enum logic {RTS_OPEN, RTS_HALT} rts_state_e;
    typedef enum logic {SC_CLEAR, SC_SEEN} sc_state_e;

    localparam logic [2:0] ADR_CTRL  = 3'd0;
    localparam logic [2:0] ADR_MODE  = 3'd1;
    localparam logic [2:0] ADR_TRIG  = 3'd2;
    localparam logic [2:0] ADR_SCHAR = 3'd3;
    localparam logic [2:0] ADR_DIVL  = 3'd4;
    localparam logic [2:0] ADR_DIVH  = 3'd5;
endpackage

// File: rtl/flow_regs.sv
module flow_regs
    import flow_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic                cts_en,
    output logic                rts_en,
    output logic                sc_en,
    output logic                sw_rts,
    output logic [DATA_W-1:0]   trig,
    output logic [DATA_W-1:0]   schar,
    output logic [2*DATA_W-1:0] baud_div
);
    logic enh_en;
    logic sleep_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cts_en   <= 1'b0;
            rts_en   <= 1'b0;
            sc_en    <= 1'b0;
            enh_en   <= 1'b0;
            sw_rts   <= 1'b0;
            sleep_q  <= 1'b0;
            trig     <= '0;
            schar    <= '0;
            baud_div <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADR_CTRL: begin
                    cts_en <= wr_data[7];
                    rts_en <= wr_data[6];
                    sc_en  <= wr_data[5];
                    enh_en <= wr_data[4];
                end
                ADR_MODE: begin
                    sw_rts <= wr_data[0];
                    if (enh_en) sleep_q <= wr_data[1];
                end
                ADR_TRIG:  if (enh_en) trig <= wr_data;
                ADR_SCHAR: schar <= wr_data;
                ADR_DIVL:  if (!sleep_q) baud_div[DATA_W-1:0] <= wr_data;
                ADR_DIVH:  if (!sleep_q) baud_div[2*DATA_W-1:DATA_W] <= wr_data;
                default: ;
            endcase
        end
    end

    // R11
    trig_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enh_en && wr_en && wr_addr == ADR_TRIG) |=> $stable(trig));

    // R12
    div_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_q && wr_en && (wr_addr == ADR_DIVL || wr_addr == ADR_DIVH)) |=> $stable(baud_div));
endmodule

// File: rtl/cts_gate.sv
module cts_gate
    import flow_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_en,
    input  logic cts_pin,
    input  logic tx_idle,
    output logic tx_permit
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   cts_s;
    tx_state_e              state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], cts_pin};
    end
    assign cts_s = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_RUN:   if (cts_en && cts_s) state_d = tx_idle ? TX_HOLD : TX_DRAIN;
            TX_DRAIN: if (!cts_en || !cts_s) state_d = TX_RUN;
                      else if (tx_idle)      state_d = TX_HOLD;
            TX_HOLD:  if (!cts_en || !cts_s) state_d = TX_RUN;
            default:  state_d = TX_RUN;
        endcase
    end

    always_comb begin
        tx_permit = (state_q != TX_HOLD);
    end

    // R3
    permit_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_permit) |-> $past(tx_idle));

    // R4
    permit_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cts_en && $past(!cts_en)) |-> tx_permit);
endmodule

// File: rtl/rts_hyst.sv
module rts_hyst
    import flow_pkg::*;
#(
    parameter int CNT_W = 7,
    parameter int NIB_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rts_en,
    input  logic               sw_rts,
    input  logic [2*NIB_W-1:0] trig,
    input  logic [CNT_W-1:0]   fifo_cnt,
    output logic               rts_pin
);
    localparam int LVL_W = NIB_W + 2;

    logic [CNT_W-1:0] halt_lvl, resume_lvl;
    rts_state_e       state_q, state_d;

    assign halt_lvl   = CNT_W'({trig[NIB_W-1:0], 2'b00});
    assign resume_lvl = CNT_W'({trig[2*NIB_W-1:NIB_W], 2'b00});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RTS_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!rts_en) begin
            state_d = RTS_OPEN;
        end else begin
            unique case (state_q)
                RTS_OPEN: if (fifo_cnt >= halt_lvl) state_d = RTS_HALT;
                RTS_HALT: if (fifo_cnt <= resume_lvl && fifo_cnt < halt_lvl) state_d = RTS_OPEN;
                default:  state_d = RTS_OPEN;
            endcase
        end
    end

    always_comb begin
        rts_pin = rts_en ? (state_q == RTS_HALT) : sw_rts;
    end

    // R5
    rts_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rts_pin) && rts_en && $past(rts_en)) |-> $past(fifo_cnt >= halt_lvl));

    // R6
    rts_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rts_pin) && rts_en && $past(rts_en)) |-> $past(fifo_cnt <= resume_lvl));

    initial begin
        lvl_fit_chk: assert (LVL_W <= CNT_W);
    end
endmodule

// File: rtl/spec_char_det.sv
module spec_char_det
    import flow_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sc_en,
    input  logic [DATA_W-1:0] schar,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              isr_rd,
    output logic              sc_irq
);
    logic      rd_q;
    logic      hit;
    logic      clr;
    sc_state_e state_q, state_d;

    assign hit = sc_en && rx_valid && (rx_data == schar);
    assign clr = isr_rd && !rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SC_CLEAR;
            rd_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            rd_q    <= isr_rd;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SC_CLEAR: if (hit)         state_d = SC_SEEN;
            SC_SEEN:  if (clr && !hit) state_d = SC_CLEAR;
            default:  state_d = SC_CLEAR;
        endcase
    end

    always_comb begin
        sc_irq = (state_q == SC_SEEN);
    end

    // R8
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sc_irq) |-> $past(sc_en && rx_valid && rx_data == schar));

    // R10
    irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(isr_rd) && !(sc_en && rx_valid && rx_data == schar)) |=> !sc_irq);
endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl
    import flow_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 3,
    parameter int FIFO_DEPTH  = 64,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cts_pin,
    input  logic                tx_idle,
    output logic                tx_permit,
    input  logic [CNT_W-1:0]    rx_fifo_cnt,
    output logic                rts_pin,
    input  logic                rx_valid,
    input  logic [DATA_W-1:0]   rx_data,
    output logic                rx_fifo_wr,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                isr_rd,
    output logic                sc_irq,
    output logic [2*DATA_W-1:0] baud_div
);
    logic              cts_en, rts_en, sc_en, sw_rts;
    logic [DATA_W-1:0] trig, schar;

    flow_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cts_en(cts_en), .rts_en(rts_en), .sc_en(sc_en), .sw_rts(sw_rts),
        .trig(trig), .schar(schar), .baud_div(baud_div)
    );

    cts_gate #(.SYNC_STAGES(SYNC_STAGES)) cts_i (
        .clk(clk), .rst_n(rst_n), .cts_en(cts_en), .cts_pin(cts_pin),
        .tx_idle(tx_idle), .tx_permit(tx_permit)
    );

    rts_hyst #(.CNT_W(CNT_W), .NIB_W(DATA_W/2)) rts_i (
        .clk(clk), .rst_n(rst_n), .rts_en(rts_en), .sw_rts(sw_rts),
        .trig(trig), .fifo_cnt(rx_fifo_cnt), .rts_pin(rts_pin)
    );

    spec_char_det #(.DATA_W(DATA_W)) sc_i (
        .clk(clk), .rst_n(rst_n), .sc_en(sc_en), .schar(schar),
        .rx_valid(rx_valid), .rx_data(rx_data), .isr_rd(isr_rd), .sc_irq(sc_irq)
    );

    assign rx_fifo_wr = rx_valid;

    // R9
    fifo_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && sc_en && rx_data == schar) |-> rx_fifo_wr);
endmodule

// File: tb/uart_flow_ctrl_tb.sv
module uart_flow_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cts_pin = 1'b0;
    logic        tx_idle = 1'b1;
    logic        tx_permit;
    logic [6:0]  rx_fifo_cnt = '0;
    logic        rts_pin;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_fifo_wr;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        isr_rd = 1'b0;
    logic        sc_irq;
    logic [15:0] baud_div;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    uart_flow_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cts_pin(cts_pin), .tx_idle(tx_idle),
        .tx_permit(tx_permit), .rx_fifo_cnt(rx_fifo_cnt), .rts_pin(rts_pin),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_fifo_wr(rx_fifo_wr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .isr_rd(isr_rd),
        .sc_irq(sc_irq), .baud_div(baud_div)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic rx_byte(input logic [7:0] d);
        rx_valid = 1'b1; rx_data = d;
        #1;
        chk("R9 fifo write strobe", 32'(rx_fifo_wr), 32'd1);
        tick(1);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 rts", 32'(rts_pin), 32'd0);
        chk("R1 permit", 32'(tx_permit), 32'd1);
        chk("R1 irq", 32'(sc_irq), 32'd0);
        chk("R1 divisor", 32'(baud_div), 32'd0);
    endtask

    task automatic t_cts_off();
        cts_pin = 1'b1; tick(4);
        chk("R4 permit with cts disabled", 32'(tx_permit), 32'd1);
        cts_pin = 1'b0; tick(4);
    endtask

    task automatic t_cts_idle();
        wr(3'd0, 8'h80);
        tx_idle = 1'b1;
        cts_pin = 1'b1; tick(2);
        chk("R2 permit before sync", 32'(tx_permit), 32'd1);
        tick(1);
        chk("R2 permit paused", 32'(tx_permit), 32'd0);
        cts_pin = 1'b0; tick(2);
        chk("R2 still paused", 32'(tx_permit), 32'd0);
        tick(1);
        chk("R2 permit resumed", 32'(tx_permit), 32'd1);
    endtask

    task automatic t_cts_midchar();
        tx_idle = 1'b0;
        cts_pin = 1'b1; tick(5);
        chk("R3 permit mid-character", 32'(tx_permit), 32'd1);
        tx_idle = 1'b1; tick(1);
        chk("R3 permit at boundary", 32'(tx_permit), 32'd0);
        cts_pin = 1'b0; tick(4);
        chk("R3 permit after cts low", 32'(tx_permit), 32'd1);
    endtask

    task automatic t_rts_sw();
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h01);
        chk("R7 rts follows soft bit high", 32'(rts_pin), 32'd1);
        wr(3'd1, 8'h00);
        chk("R7 rts follows soft bit low", 32'(rts_pin), 32'd0);
    endtask

    task automatic t_rts_hyst();
        wr(3'd0, 8'h40);
        wr(3'd2, 8'h14);
        rx_fifo_cnt = 7'd2; tick(1);
        chk("R11 trigger write ignored", 32'(rts_pin), 32'd1);
        wr(3'd0, 8'h50);
        wr(3'd2, 8'h14);
        tick(1);
        chk("R11 trigger written when enabled", 32'(rts_pin), 32'd0);
        rx_fifo_cnt = 7'd15; tick(1);
        chk("R5 below halt", 32'(rts_pin), 32'd0);
        rx_fifo_cnt = 7'd16; tick(1);
        chk("R5 halt reached", 32'(rts_pin), 32'd1);
        rx_fifo_cnt = 7'd10; tick(1);
        chk("R6 hold high in band", 32'(rts_pin), 32'd1);
        rx_fifo_cnt = 7'd5; tick(1);
        chk("R6 above resume", 32'(rts_pin), 32'd1);
        rx_fifo_cnt = 7'd4; tick(1);
        chk("R6 resume reached", 32'(rts_pin), 32'd0);
        rx_fifo_cnt = 7'd10; tick(1);
        chk("R6 hold low in band", 32'(rts_pin), 32'd0);
        rx_fifo_cnt = 7'd64; tick(1);
        chk("R5 full fifo", 32'(rts_pin), 32'd1);
        rx_fifo_cnt = 7'd0; tick(1);
        chk("R6 empty fifo", 32'(rts_pin), 32'd0);
    endtask

    task automatic t_special();
        wr(3'd0, 8'h20);
        wr(3'd3, 8'h7E);
        rx_byte(8'h55);
        chk("R8 no match", 32'(sc_irq), 32'd0);
        rx_byte(8'h7E);
        chk("R8 match sets flag", 32'(sc_irq), 32'd1);
        tick(3);
        chk("R10 flag sticky", 32'(sc_irq), 32'd1);
        isr_rd = 1'b1; tick(1);
        chk("R10 read clears", 32'(sc_irq), 32'd0);
        rx_byte(8'h7E);
        tick(2);
        chk("R10 held read no second clear", 32'(sc_irq), 32'd1);
        isr_rd = 1'b0; tick(1);
        isr_rd = 1'b1; rx_valid = 1'b1; rx_data = 8'h7E; tick(1);
        rx_valid = 1'b0;
        chk("R10 set wins over clear", 32'(sc_irq), 32'd1);
        isr_rd = 1'b0; tick(1);
        isr_rd = 1'b1; tick(1);
        isr_rd = 1'b0;
        chk("R10 clear edge", 32'(sc_irq), 32'd0);
        wr(3'd0, 8'h00);
        rx_byte(8'h7E);
        chk("R8 disabled no flag", 32'(sc_irq), 32'd0);
    endtask

    task automatic t_divisor();
        wr(3'd1, 8'h02);
        wr(3'd4, 8'h34);
        wr(3'd5, 8'h12);
        chk("R11 sleep write ignored, R12 divisor", 32'(baud_div), 32'h1234);
        wr(3'd0, 8'h10);
        wr(3'd1, 8'h02);
        wr(3'd4, 8'hFF);
        wr(3'd5, 8'hEE);
        chk("R12 divisor locked in sleep", 32'(baud_div), 32'h1234);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_cts_off();
        t_cts_idle();
        t_cts_midchar();
        t_rts_sw();
        t_rts_hyst();
        t_special();
        t_divisor();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule